// File: doc/BRIEF.md
# Slave-Port Arbiter with Slot Limit

This block decides which of `NUM_MASTERS` bus masters may drive one slave port. Each master holds its request line high for as long as it wants the slave. A request falling marks the end of that master's access. The block returns a registered grant vector with at most one bit set. When several masters want the slave, the winner is chosen in round-robin order, and the search starts from the master after the one granted last.

A programmable slot limit bounds how long one master keeps the slave while others wait. Once the owner has held the grant for the programmed number of clock cycles and a competitor is requesting, the grant moves at the next edge. If no competitor is requesting, the owner keeps the grant. A limit of zero turns this off. When nothing is requested, a parking policy decides where the grant rests. It can go to nothing, which costs one clock on the next access. It can stay with the last owner, or go to a programmed fixed master, and that master then starts with no delay. A 32-bit configuration word holds these settings and can be locked by a write-protect input.

The control is a three-state machine. `ARB_IDLE` grants nobody. `ARB_OWNED` grants a master that is requesting. `ARB_PARKED` grants a master that is not requesting. The transitions are as follows. A grant event enters `ARB_OWNED` from any state. It is taken when a request wins from idle or parked, when the parked master starts requesting, on a slot break, or on a hand-off after the owner releases. Park entry goes to `ARB_PARKED` or `ARB_IDLE`, according to the policy, when no request is pending. Hold keeps the current state.

Top module: `slot_arbiter`

## Requirements
- R1: `gnt` is always zero or one-hot; bit i grants master i.
- R2: With park type 0 or 3 (no parking), `gnt` is zero on the cycle after a clock edge at which no request is present, and a request raised from that idle state is granted at the following edge, one clock later.
- R3: With park type 1, an idle slave keeps the grant on the last master that owned it, so that master's request is already granted in the cycle it is raised.
- R4: With park type 2, an idle slave is granted to the master numbered in configuration bits 21:18; a number not below `NUM_MASTERS` behaves as no parking.
- R5: Among competing requesters the grant goes to the first one found in the order last owner + 1, last owner + 2, and so on modulo `NUM_MASTERS`.
- R6: With slot limit L (bits 8:0) greater than zero and another master requesting, the owner holds the grant for exactly L consecutive cycles before it moves to the round-robin winner among the others.
- R7: Without a competitor the owner keeps the grant past L cycles; a competitor that appears after the owner has held L or more cycles takes the grant at the next edge.
- R8: With slot limit 0, the owner keeps the grant while its request is high, whatever the other requests.
- R9: When the owner drops its request while another master requests, the grant passes to the round-robin winner at the next edge with no idle cycle.
- R10: A write with `cfg_wp` low stores the word; read-back shows slot limit in 8:0, park type in 17:16, fixed master in 21:18, and zero in every other bit.
- R11: A write while `cfg_wp` is high leaves the stored word and the arbitration behaviour unchanged.
- R12: After reset `gnt` is zero and `cfg_rdata` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| req | input | NUM_MASTERS | Request line per master, high for the length of an access |
| gnt | output | NUM_MASTERS | Registered grant, zero or one-hot |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wp | input | 1 | Write-protect enable; writes are dropped while high |
| cfg_wdata | input | 32 | Configuration write word |
| cfg_rdata | output | 32 | Stored configuration word |

## Verification
The bench aims at the slot boundary. It checks that the grant moves after exactly L cycles under contention, including L = 1 where the grant alternates every cycle. It also checks a late competitor against a saturated counter. A counter off by one would shift the break by a cycle, and one that did not saturate would make the late competitor wait a whole new slot. The parking cases are checked for the zero-latency grant, for a fixed master number beyond the last master, and for type 3. A design that parked on a wrong index, or treated type 3 as a valid policy, would show a grant where none is expected. The checks also cover a hand-off without an idle gap and a protected write. A design that lost the hand-off would insert a zero-grant cycle, and one that ignored protection would change the read-back and the slot behaviour.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;

    localparam int CFG_W    = 32;
    localparam int SLOT_W   = 9;
    localparam int SLOT_LSB = 0;
    localparam int PARK_W   = 2;
    localparam int PARK_LSB = 16;
    localparam int FIX_W    = 4;
    localparam int FIX_LSB  = 18;

    localparam logic [CFG_W-1:0] CFG_MASK =
        ({{(CFG_W-SLOT_W){1'b0}}, {SLOT_W{1'b1}}} << SLOT_LSB) |
        ({{(CFG_W-PARK_W){1'b0}}, {PARK_W{1'b1}}} << PARK_LSB) |
        ({{(CFG_W-FIX_W){1'b0}},  {FIX_W{1'b1}}}  << FIX_LSB);

    typedef enum logic [1:0] {
        ARB_IDLE   = 2'd0,
        ARB_OWNED  = 2'd1,
        ARB_PARKED = 2'd2
    } arb_state_e;

    typedef enum logic [PARK_W-1:0] {
        PARK_NONE  = 2'd0,
        PARK_LAST  = 2'd1,
        PARK_FIXED = 2'd2,
        PARK_NONE3 = 2'd3
    } park_e;

endpackage

// File: rtl/slot_arb_cfg.sv
module slot_arb_cfg
    import slot_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              wp,
    input  logic [CFG_W-1:0]  wdata,
    output logic [CFG_W-1:0]  rdata,
    output logic [SLOT_W-1:0] slot_lim,
    output park_e             park_type,
    output logic [FIX_W-1:0]  fixed_num
);

    logic [CFG_W-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (we && !wp) begin
            cfg_q <= wdata & CFG_MASK;
        end
    end

    always_comb begin
        rdata     = cfg_q;
        slot_lim  = cfg_q[SLOT_LSB +: SLOT_W];
        park_type = park_e'(cfg_q[PARK_LSB +: PARK_W]);
        fixed_num = cfg_q[FIX_LSB +: FIX_W];
    end

    // R10: an unprotected write lands masked on the next cycle
    p_write_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wp) |=> (rdata == ($past(wdata) & CFG_MASK)));

    // R11: a protected write changes nothing
    p_wp_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wp) |=> $stable(rdata));

endmodule

// File: rtl/slot_arb_rr.sv
module slot_arb_rr #(
    parameter int NUM_MASTERS = 4,
    parameter int IDX_W       = 2
) (
    input  logic [NUM_MASTERS-1:0] mask,
    input  logic [IDX_W-1:0]       ptr,
    output logic                   vld,
    output logic [IDX_W-1:0]       idx
);

    // Walk offsets from far to near so the nearest requester after ptr wins.
    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int off = NUM_MASTERS; off >= 1; off--) begin
            int cand;
            cand = (int'(ptr) + off) % NUM_MASTERS;
            if (mask[cand]) begin
                vld = 1'b1;
                idx = IDX_W'(cand);
            end
        end
    end

endmodule

// File: rtl/slot_arb_timer.sv
module slot_arb_timer
    import slot_arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              run,
    input  logic [SLOT_W-1:0] limit,
    output logic              expired
);

    logic [SLOT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (run && (cnt_q < limit)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // cnt_q = cycles already completed by the owner; the current one is the last allowed
    assign expired = (limit != '0) && (cnt_q >= (limit - 1'b1));

    // R6: an arbitration event restarts the count
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));

    // R7: once at the limit the count holds until the next event
    p_cnt_sat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clear && (cnt_q >= limit)) |=> $stable(cnt_q));

endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
    import slot_arb_pkg::*;
#(
    parameter int NUM_MASTERS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_MASTERS-1:0] req,
    output logic [NUM_MASTERS-1:0] gnt,
    input  logic                   cfg_we,
    input  logic                   cfg_wp,
    input  logic [CFG_W-1:0]       cfg_wdata,
    output logic [CFG_W-1:0]       cfg_rdata
);

    localparam int IDX_W = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;

    arb_state_e        state_q, state_d;
    logic [IDX_W-1:0]  owner_q, owner_d;
    logic [IDX_W-1:0]  last_q;
    logic              grant_evt;

    logic [SLOT_W-1:0] slot_lim;
    park_e             park_type;
    logic [FIX_W-1:0]  fixed_num;
    logic              fixed_ok;

    logic [NUM_MASTERS-1:0] owner_oh;
    logic [NUM_MASTERS-1:0] fixed_oh;
    logic [NUM_MASTERS-1:0] rr_mask;
    logic                   win_vld;
    logic [IDX_W-1:0]       win_idx;
    logic                   expired;
    logic                   owner_req;

    slot_arb_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .wp        (cfg_wp),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .slot_lim  (slot_lim),
        .park_type (park_type),
        .fixed_num (fixed_num)
    );

    slot_arb_rr #(
        .NUM_MASTERS (NUM_MASTERS),
        .IDX_W       (IDX_W)
    ) u_rr (
        .mask (rr_mask),
        .ptr  (last_q),
        .vld  (win_vld),
        .idx  (win_idx)
    );

    slot_arb_timer u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (grant_evt),
        .run     (state_q == ARB_OWNED),
        .limit   (slot_lim),
        .expired (expired)
    );

    always_comb begin
        owner_oh = '0;
        owner_oh[owner_q] = 1'b1;
        fixed_ok = int'(fixed_num) < NUM_MASTERS;
        fixed_oh = '0;
        if (fixed_ok) fixed_oh[fixed_num[IDX_W-1:0]] = 1'b1;
        owner_req = |(req & owner_oh);
        // the owner never competes against itself
        rr_mask = (state_q == ARB_OWNED) ? (req & ~owner_oh) : req;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            owner_q <= '0;
            last_q  <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            if (grant_evt) last_q <= owner_d;
        end
    end

    // next state
    always_comb begin
        state_d   = state_q;
        owner_d   = owner_q;
        grant_evt = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                if (win_vld) begin
                    state_d   = ARB_OWNED;
                    owner_d   = win_idx;
                    grant_evt = 1'b1;
                end
            end
            ARB_OWNED: begin
                if (owner_req) begin
                    if (expired && win_vld) begin
                        owner_d   = win_idx;
                        grant_evt = 1'b1;
                    end
                end else if (win_vld) begin
                    owner_d   = win_idx;
                    grant_evt = 1'b1;
                end
            end
            ARB_PARKED: begin
                if (owner_req) begin
                    state_d   = ARB_OWNED;
                    grant_evt = 1'b1;
                end else if (win_vld) begin
                    state_d   = ARB_OWNED;
                    owner_d   = win_idx;
                    grant_evt = 1'b1;
                end
            end
            default: begin
                state_d = ARB_IDLE;
            end
        endcase

        // park entry: nobody is asking for the slave
        if (req == '0) begin
            unique case (park_type)
                PARK_LAST: begin
                    state_d = ARB_PARKED;
                    owner_d = last_q;
                end
                PARK_FIXED: begin
                    if (fixed_ok) begin
                        state_d = ARB_PARKED;
                        owner_d = fixed_num[IDX_W-1:0];
                    end else begin
                        state_d = ARB_IDLE;
                    end
                end
                default: begin
                    state_d = ARB_IDLE;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        gnt = (state_q == ARB_IDLE) ? '0 : owner_oh;
    end

    p_gnt_onehot0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    p_idle_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((req == '0) && (park_type == PARK_NONE || park_type == PARK_NONE3))
        |=> (gnt == '0));

    p_park_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((req == '0) && (park_type == PARK_LAST) && (gnt != '0)) |=> $stable(gnt));

    p_park_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((req == '0) && (park_type == PARK_FIXED)) |=> (gnt == $past(fixed_oh)));

    p_slot_break_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ARB_OWNED) && owner_req && expired && ((req & ~gnt) != '0))
        |=> (gnt != $past(gnt)));

    p_no_limit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((slot_lim == '0) && (state_q == ARB_OWNED) && owner_req) |=> $stable(gnt));

    p_handoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ARB_OWNED) && !owner_req && (req != '0))
        |=> ((gnt & $past(req)) != '0));

endmodule

// File: tb/slot_arbiter_tb_top.sv
module slot_arbiter_tb_top;

    localparam int N = 4;
    localparam int NV = 21;
    // {req, expected gnt} with park type 0 and slot limit 3
    localparam logic [7:0] VEC [NV] = '{
        8'h11, 8'h31, 8'h31, 8'h32, 8'h32, 8'h32, 8'h31,
        8'h11, 8'h11, 8'h11, 8'h11, 8'h98, 8'hC8, 8'h44,
        8'h00, 8'h22, 8'h00, 8'hF4, 8'hB8, 8'h31, 8'h00
    };
    localparam int VTAG [NV] = '{
        5, 6, 6, 6, 6, 6, 6, 7, 7, 7, 7, 7, 6, 9, 2, 2, 2, 5, 9, 9, 2
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  gnt;
    logic          cfg_we = 1'b0;
    logic          cfg_wp = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    slot_arbiter #(.NUM_MASTERS(N)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .gnt       (gnt),
        .cfg_we    (cfg_we),
        .cfg_wp    (cfg_wp),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<5000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [31:0] w, input logic prot);
        cfg_wdata = w;
        cfg_wp    = prot;
        cfg_we    = 1'b1;
        step();
        cfg_we    = 1'b0;
        cfg_wp    = 1'b0;
    endtask

    initial begin
        step(); step();
        rst_n = 1'b1;
        #1;
        check("R12 reset gnt", 32'(gnt), 32'h0);
        check("R12 reset cfg", cfg_rdata, 32'h0);

        // R10: reserved bits are dropped
        cfg_write(32'hFFC0_FE03, 1'b0);
        check("R10 masked readback", cfg_rdata, 32'h0000_0003);
        // R11: protected write is ignored
        cfg_write(32'h0001_01FF, 1'b1);
        check("R11 protected write", cfg_rdata, 32'h0000_0003);

        // table: R5 R6 R7 R9 R2 under slot limit 3, no parking
        for (int i = 0; i < NV; i++) begin
            req = VEC[i][7:4];
            step();
            n_cmp++;
            if (gnt !== VEC[i][3:0]) begin
                n_bad++;
                $display("FAIL R%0d table row %0d: act=%b exp=%b", VTAG[i], i, gnt, VEC[i][3:0]);
            end
        end

        // R3: park on last owner (master 0)
        cfg_write(32'h0001_0003, 1'b0);
        step();
        check("R3 park last", 32'(gnt), 32'h1);
        req = 4'b0001;
        #1;
        check("R3 zero latency", 32'(gnt), 32'h1);
        step();
        check("R3 owned", 32'(gnt), 32'h1);
        req = 4'b0100;
        step();
        check("R9 handoff", 32'(gnt), 32'h4);
        req = 4'b0000;
        step();
        check("R3 park on new last", 32'(gnt), 32'h4);

        // R4: fixed master 3
        cfg_write(32'h000E_0003, 1'b0);
        check("R10 fixed readback", cfg_rdata, 32'h000E_0003);
        step();
        check("R4 park fixed", 32'(gnt), 32'h8);
        req = 4'b1000;
        #1;
        check("R4 zero latency", 32'(gnt), 32'h8);
        step();
        check("R4 owned", 32'(gnt), 32'h8);
        req = 4'b0001;
        step();
        check("R5 after fixed", 32'(gnt), 32'h1);
        req = 4'b0000;
        step();
        check("R4 back to fixed", 32'(gnt), 32'h8);

        // R4: out-of-range fixed number
        cfg_write(32'h0026_0003, 1'b0);
        step();
        check("R4 fixed out of range", 32'(gnt), 32'h0);

        // R2: type 3 behaves as none
        cfg_write(32'h0001_0003, 1'b0);
        step();
        check("R3 park last again", 32'(gnt), 32'h1);
        cfg_write(32'h0003_0003, 1'b0);
        step();
        check("R2 type3 idle", 32'(gnt), 32'h0);

        // R8: slot limit zero
        cfg_write(32'h0000_0000, 1'b0);
        req = 4'b0001;
        step();
        check("R2 one-clock grant", 32'(gnt), 32'h1);
        req = 4'b0011;
        for (int k = 0; k < 20; k++) begin
            step();
            check("R8 no limit hold", 32'(gnt), 32'h1);
        end
        req = 4'b0010;
        step();
        check("R9 release", 32'(gnt), 32'h2);

        // R6: slot limit 1 alternates every cycle
        cfg_write(32'h0000_0001, 1'b0);
        check("R8 hold during write", 32'(gnt), 32'h2);
        req = 4'b0011;
        step();
        check("R6 L1 first", 32'(gnt), 32'h1);
        step();
        check("R6 L1 second", 32'(gnt), 32'h2);
        step();
        check("R6 L1 third", 32'(gnt), 32'h1);
        check("R1 onehot", 32'($countones(gnt)), 32'h1);

        req = '0;
        step();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule